// File: doc/BRIEF.md
# Bus-Mastered ADC Sensor Sequencer

This block is a thermal-monitor sequencer that has no converter of its own. On a fixed schedule it runs a round of conversions on an external ADC. It does this by acting as master on a simple memory-mapped bus. For each enabled sensing point, in ascending index order, it first issues a set of configuration writes: the analog-mux code for that point, an optional converter-mux word, two optional extra words and an ADC-enable word. It then reads a data address repeatedly until a valid flag shows up in the returned word. Finally it extracts a 12-bit sample into that point's result register.

All addresses, write values, the valid-flag description, the shift amount and the timing fields come from configuration inputs. These are driven by the surrounding register file and are held stable while a round is in progress. The timing fields are a prescaler, a sense interval, a filter interval, a poll gap and a poll timeout.

Top module: `adc_seq_master`

## Requirements
- R1: After reset `m_req` is low, every `res_valid` bit is 0 and `tmo_pulse` is low.
- R2: Within a round the points whose bit is set in `cfg_point_en` are converted one at a time, in ascending index order. A point whose bit is clear causes no bus traffic, and its result and flag keep their values.
- R3: For each converted point the optional writes are issued in a fixed order. They are controlled by these bits of `cfg_wr_ctrl`:
  - bit 0: the point's 8-bit mux code, taken from `cfg_pnp_code[8p+7:8p]` and zero-extended, is written to `cfg_pnp_addr`.
  - bit 1: `cfg_adcmux_val` is written to `cfg_adcmux_addr`.
  - bit 2: `cfg_ext_val` is written to `cfg_ext_addr`.
  - bit 3: `cfg_ext1_val` is written to `cfg_ext1_addr`.
  - A clear bit skips its write.
- R4: After the optional writes, `cfg_en_val` is always written to `cfg_en_addr`. Polling starts only after that.
- R5: Polling reads `cfg_data_addr`, with the flag and the sample taken from the same word. After a read whose flag is not valid, the block waits at least `cfg_poll_gap` cycles and then reads again.
- R6: `cfg_valid_desc[4:0]` gives the bit position of the valid flag in the read word. When `cfg_valid_desc[5]` is 1 the flag is valid when that bit is 1; when it is 0 the flag is valid when that bit is 0.
- R7: On a valid read, the point's result becomes bits 11:0 of the read word shifted right by `cfg_vshift`, and its `res_valid` bit is set. That bit stays set until reset.
- R8: When an invalid read completes and at least `cfg_timeout` cycles have passed since polling of the point began, `tmo_pulse` is high for one cycle. The point's result is left unchanged and the sequencer moves on to the next point.
- R9: With N = `cfg_prescale` and a base unit of N*256 clocks, a round starts no sooner than `cfg_interval[9:0]` base units after the last access of the previous round. Rounds never overlap.
- R10: Between converted points of one round, the block waits at least `cfg_interval[25:16]` base units after the previous point's last access.
- R11: A request holds `m_req`, `m_we`, `m_addr` and `m_wdata` stable until the cycle in which `m_ack` is high. That cycle completes the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_point_en | input | NPT | Sensing point enable mask |
| cfg_wr_ctrl | input | 4 | Optional write enables (R3) |
| cfg_pnp_code | input | NPT*MW | Per-point sensor mux codes |
| cfg_pnp_addr | input | AW | Sensor mux bus address |
| cfg_adcmux_addr | input | AW | Converter mux bus address |
| cfg_adcmux_val | input | DW | Converter mux write value |
| cfg_ext_addr | input | AW | Extra write address |
| cfg_ext_val | input | DW | Extra write value |
| cfg_ext1_addr | input | AW | Second extra write address |
| cfg_ext1_val | input | DW | Second extra write value |
| cfg_en_addr | input | AW | ADC enable address |
| cfg_en_val | input | DW | ADC enable value |
| cfg_data_addr | input | AW | Flag and sample read address |
| cfg_valid_desc | input | 6 | Valid flag position and polarity |
| cfg_vshift | input | 5 | Right shift applied to read word |
| cfg_prescale | input | PSW | Base unit multiplier N |
| cfg_interval | input | 32 | Sense interval [9:0], filter interval [25:16] |
| cfg_poll_gap | input | CW | Minimum cycles between polls |
| cfg_timeout | input | CW | Polling time bound in cycles |
| m_req | output | 1 | Bus request |
| m_we | output | 1 | Bus write strobe |
| m_addr | output | AW | Bus address |
| m_wdata | output | DW | Bus write data |
| m_ack | input | 1 | Bus acknowledge |
| m_rdata | input | DW | Bus read data, valid with m_ack |
| res_data | output | NPT*12 | Per-point results |
| res_valid | output | NPT | Sticky per-point has-data flags |
| tmo_pulse | output | 1 | One-cycle poll timeout indication |

## Verification
The hardest conditions to reach from the ports are the abandoned point after a poll timeout and the active-low valid flag sitting at the top bit of the read word. Both depend entirely on what the bus slave returns on each individual poll. The bench's slave model therefore serves read words from a queue that the driver fills per point. The driver can queue several invalid words before a valid one, use a zero timeout so that the first invalid word abandons the point, or flip the flag polarity. The monitor then checks that the abandoned point's old result survives, and that every access arrives in the expected order with the expected spacing.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PICK,
    S_WRITE,
    S_POLL_RD,
    S_POLL_WAIT,
    S_GAP
  } seq_state_t;

  localparam int SAMPLE_W = 12;
  localparam int STEP_EN  = 4;   // write step index of the ADC enable word
endpackage

// File: rtl/adc_seq_timebase.sv
module adc_seq_timebase #(
  parameter int PSW = 8,
  parameter int UW  = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [PSW-1:0] prescale,
  output logic [UW-1:0]  units
);
  localparam int PCW = PSW + 8;

  logic [PCW-1:0] pre_q, pre_d;
  logic [UW-1:0]  unit_q, unit_d;
  logic [PCW:0]   pre_inc;
  logic [PCW:0]   limit;
  logic           tick;

  assign pre_inc = {1'b0, pre_q} + 1'b1;
  assign limit   = {1'b0, prescale, 8'h00};
  assign tick    = pre_inc >= limit;

  always_comb begin
    pre_d  = pre_q;
    unit_d = unit_q;
    if (clr) begin
      pre_d  = '0;
      unit_d = '0;
    end else if (tick) begin
      pre_d = '0;
      if (unit_q != '1) unit_d = unit_q + 1'b1;
    end else begin
      pre_d = pre_inc[PCW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      unit_q <= '0;
    end else begin
      pre_q  <= pre_d;
      unit_q <= unit_d;
    end
  end

  assign units = unit_q;
endmodule

// File: rtl/adc_seq_extract.sv
module adc_seq_extract #(
  parameter int DW = 32,
  parameter int SW = 12
) (
  input  logic [DW-1:0] word,
  input  logic [5:0]    desc,
  input  logic [4:0]    shift,
  output logic          flag_ok,
  output logic [SW-1:0] sample
);
  localparam int BW = $clog2(DW);

  logic          flag_bit;
  logic [DW-1:0] shifted;

  assign flag_bit = word[desc[BW-1:0]];
  assign flag_ok  = desc[5] ? flag_bit : ~flag_bit;
  assign shifted  = word >> shift;
  assign sample   = shifted[SW-1:0];
endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results #(
  parameter int NPT = 4,
  parameter int SW  = 12,
  localparam int IW = (NPT > 1) ? $clog2(NPT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [SW-1:0]     wr_data,
  output logic [NPT*SW-1:0] res_data,
  output logic [NPT-1:0]    res_valid
);
  for (genvar i = 0; i < NPT; i++) begin : g_pt
    logic          hit;
    logic [SW-1:0] data_q;
    logic          flag_q;

    assign hit = wr_en && (wr_idx == IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q <= '0;
        flag_q <= 1'b0;
      end else if (hit) begin
        data_q <= wr_data;
        flag_q <= 1'b1;
      end
    end

    assign res_data[i*SW +: SW] = data_q;
    assign res_valid[i]         = flag_q;
  end
endmodule

// File: rtl/adc_seq_master.sv
module adc_seq_master
  import adc_seq_pkg::*;
#(
  parameter int NPT = 4,
  parameter int DW  = 32,
  parameter int AW  = 32,
  parameter int MW  = 8,
  parameter int PSW = 8,
  parameter int UW  = 10,
  parameter int CW  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPT-1:0]          cfg_point_en,
  input  logic [3:0]              cfg_wr_ctrl,
  input  logic [NPT*MW-1:0]       cfg_pnp_code,
  input  logic [AW-1:0]           cfg_pnp_addr,
  input  logic [AW-1:0]           cfg_adcmux_addr,
  input  logic [DW-1:0]           cfg_adcmux_val,
  input  logic [AW-1:0]           cfg_ext_addr,
  input  logic [DW-1:0]           cfg_ext_val,
  input  logic [AW-1:0]           cfg_ext1_addr,
  input  logic [DW-1:0]           cfg_ext1_val,
  input  logic [AW-1:0]           cfg_en_addr,
  input  logic [DW-1:0]           cfg_en_val,
  input  logic [AW-1:0]           cfg_data_addr,
  input  logic [5:0]              cfg_valid_desc,
  input  logic [4:0]              cfg_vshift,
  input  logic [PSW-1:0]          cfg_prescale,
  input  logic [31:0]             cfg_interval,
  input  logic [CW-1:0]           cfg_poll_gap,
  input  logic [CW-1:0]           cfg_timeout,
  output logic                    m_req,
  output logic                    m_we,
  output logic [AW-1:0]           m_addr,
  output logic [DW-1:0]           m_wdata,
  input  logic                    m_ack,
  input  logic [DW-1:0]           m_rdata,
  output logic [NPT*SAMPLE_W-1:0] res_data,
  output logic [NPT-1:0]          res_valid,
  output logic                    tmo_pulse
);
  localparam int PTW = (NPT > 1) ? $clog2(NPT) : 1;
  localparam logic [PTW:0] PT_END = (PTW+1)'(NPT);

  seq_state_t     state_q, state_d;
  logic [PTW:0]   pt_q, pt_d;
  logic [2:0]     step_q, step_d;
  logic [CW-1:0]  tcnt_q, tcnt_d, tcnt_inc;
  logic [CW-1:0]  wait_q, wait_d;
  logic           tmo_q, tmo_d;

  logic [UW-1:0]       units, sense_u, filt_u;
  logic                tb_clr;
  logic [PTW-1:0]      pt_idx;
  logic                step_on;
  logic [AW-1:0]       wr_addr;
  logic [DW-1:0]       wr_data;
  logic                flag_ok;
  logic [SAMPLE_W-1:0] sample;
  logic                res_we;
  logic                unused_ivl_bits;

  assign sense_u         = cfg_interval[UW-1:0];
  assign filt_u          = cfg_interval[16 +: UW];
  assign unused_ivl_bits = ^{cfg_interval[31:16+UW], cfg_interval[15:UW]};
  assign pt_idx          = pt_q[PTW-1:0];
  assign tb_clr          = !(state_q == S_IDLE || state_q == S_GAP);
  assign tcnt_inc        = (tcnt_q == '1) ? tcnt_q : tcnt_q + 1'b1;
  assign step_on         = (step_q == 3'(STEP_EN)) || cfg_wr_ctrl[step_q[1:0]];

  adc_seq_timebase #(.PSW(PSW), .UW(UW)) u_tb (
    .clk(clk), .rst_n(rst_n), .clr(tb_clr), .prescale(cfg_prescale), .units(units)
  );

  adc_seq_extract #(.DW(DW), .SW(SAMPLE_W)) u_ext (
    .word(m_rdata), .desc(cfg_valid_desc), .shift(cfg_vshift),
    .flag_ok(flag_ok), .sample(sample)
  );

  // write step selection: pnp mux, adc mux, extra, extra1, enable
  always_comb begin
    case (step_q)
      3'd0:    begin wr_addr = cfg_pnp_addr;    wr_data = DW'(cfg_pnp_code[pt_idx*MW +: MW]); end
      3'd1:    begin wr_addr = cfg_adcmux_addr; wr_data = cfg_adcmux_val; end
      3'd2:    begin wr_addr = cfg_ext_addr;    wr_data = cfg_ext_val;    end
      3'd3:    begin wr_addr = cfg_ext1_addr;   wr_data = cfg_ext1_val;   end
      default: begin wr_addr = cfg_en_addr;     wr_data = cfg_en_val;     end
    endcase
  end

  assign m_req   = (state_q == S_WRITE && step_on) || state_q == S_POLL_RD;
  assign m_we    = state_q == S_WRITE;
  assign m_addr  = (state_q == S_POLL_RD) ? cfg_data_addr : wr_addr;
  assign m_wdata = (state_q == S_WRITE) ? wr_data : '0;
  assign res_we  = state_q == S_POLL_RD && m_ack && flag_ok;

  always_comb begin
    state_d = state_q;
    pt_d    = pt_q;
    step_d  = step_q;
    tcnt_d  = tcnt_q;
    wait_d  = wait_q;
    tmo_d   = 1'b0;
    case (state_q)
      S_IDLE: if (units >= sense_u) begin
        state_d = S_PICK;
        pt_d    = '0;
      end
      S_PICK: begin
        if (pt_q == PT_END) state_d = S_IDLE;
        else if (cfg_point_en[pt_idx]) begin
          state_d = S_WRITE;
          step_d  = '0;
        end else pt_d = pt_q + 1'b1;
      end
      S_WRITE: begin
        if (!step_on) step_d = step_q + 1'b1;
        else if (m_ack) begin
          if (step_q == 3'(STEP_EN)) begin
            state_d = S_POLL_RD;
            tcnt_d  = '0;
          end else step_d = step_q + 1'b1;
        end
      end
      S_POLL_RD: begin
        tcnt_d = tcnt_inc;
        if (m_ack) begin
          if (flag_ok) state_d = S_GAP;
          else if (tcnt_q >= cfg_timeout) begin
            tmo_d   = 1'b1;
            state_d = S_GAP;
          end else begin
            state_d = S_POLL_WAIT;
            wait_d  = '0;
          end
        end
      end
      S_POLL_WAIT: begin
        tcnt_d = tcnt_inc;
        if (wait_q >= cfg_poll_gap) state_d = S_POLL_RD;
        else wait_d = wait_q + 1'b1;
      end
      S_GAP: if (units >= filt_u) begin
        state_d = S_PICK;
        pt_d    = pt_q + 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pt_q    <= '0;
      step_q  <= '0;
      tcnt_q  <= '0;
      wait_q  <= '0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pt_q    <= pt_d;
      step_q  <= step_d;
      tcnt_q  <= tcnt_d;
      wait_q  <= wait_d;
      tmo_q   <= tmo_d;
    end
  end

  assign tmo_pulse = tmo_q;

  adc_seq_results #(.NPT(NPT), .SW(SAMPLE_W)) u_res (
    .clk(clk), .rst_n(rst_n), .wr_en(res_we), .wr_idx(pt_idx),
    .wr_data(sample), .res_data(res_data), .res_valid(res_valid)
  );
endmodule

// File: rtl/adc_seq_master_chk.sv
module adc_seq_master_chk #(
  parameter int NPT = 4,
  parameter int DW  = 32,
  parameter int AW  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m_req,
  input logic              m_we,
  input logic [AW-1:0]     m_addr,
  input logic [DW-1:0]     m_wdata,
  input logic              m_ack,
  input logic [AW-1:0]     cfg_data_addr,
  input logic [NPT-1:0]    cfg_point_en,
  input logic [NPT*12-1:0] res_data,
  input logic [NPT-1:0]    res_valid,
  input logic              tmo_pulse
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && !m_ack |=> m_req && $stable(m_we) && $stable(m_addr) && $stable(m_wdata));

  // R5
  rd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && !m_we |-> m_addr == cfg_data_addr);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid & $past(res_valid)) == $past(res_valid));

  // R8
  tmo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |=> !tmo_pulse);

  // R8
  tmo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |-> $stable(res_data));

  for (genvar i = 0; i < NPT; i++) begin : g_en
    // R2
    en_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(res_valid[i]) |-> cfg_point_en[i]);
  end
endmodule

bind adc_seq_master adc_seq_master_chk #(.NPT(NPT), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
  .m_wdata(m_wdata), .m_ack(m_ack), .cfg_data_addr(cfg_data_addr),
  .cfg_point_en(cfg_point_en), .res_data(res_data), .res_valid(res_valid),
  .tmo_pulse(tmo_pulse)
);

// File: tb/adc_seq_master_test.sv
module adc_seq_master_test;
  localparam int UNIT = 256;   // prescale 1
  localparam int SENSE = 2;
  localparam int FILT = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]  cfg_point_en = '0;
  logic [3:0]  cfg_wr_ctrl = '0;
  logic [31:0] cfg_pnp_code = 32'h4332_2110;
  logic [31:0] cfg_pnp_addr = 32'h1000_0604;
  logic [31:0] cfg_adcmux_addr = 32'h2000_000C;
  logic [31:0] cfg_adcmux_val = 32'h0000_0800;
  logic [31:0] cfg_ext_addr = 32'h2000_0020;
  logic [31:0] cfg_ext_val = 32'hA5A5_0001;
  logic [31:0] cfg_ext1_addr = 32'h2000_0024;
  logic [31:0] cfg_ext1_val = 32'h5A5A_0002;
  logic [31:0] cfg_en_addr = 32'h2000_0008;
  logic [31:0] cfg_en_val = 32'h0000_0800;
  logic [31:0] cfg_data_addr = 32'h2000_0040;
  logic [5:0]  cfg_valid_desc = 6'h2C;
  logic [4:0]  cfg_vshift = '0;
  logic [7:0]  cfg_prescale = 8'd1;
  logic [31:0] cfg_interval = {6'd0, 10'(FILT), 6'd0, 10'(SENSE)};
  logic [15:0] cfg_poll_gap = 16'd3;
  logic [15:0] cfg_timeout = 16'hFFFF;

  logic        m_req, m_we;
  logic [31:0] m_addr, m_wdata;
  logic        m_ack = 1'b0;
  logic [31:0] m_rdata = '0;
  logic [47:0] res_data;
  logic [3:0]  res_valid;
  logic        tmo_pulse;

  adc_seq_master uut (
    .clk(clk), .rst_n(rst_n), .cfg_point_en(cfg_point_en), .cfg_wr_ctrl(cfg_wr_ctrl),
    .cfg_pnp_code(cfg_pnp_code), .cfg_pnp_addr(cfg_pnp_addr),
    .cfg_adcmux_addr(cfg_adcmux_addr), .cfg_adcmux_val(cfg_adcmux_val),
    .cfg_ext_addr(cfg_ext_addr), .cfg_ext_val(cfg_ext_val),
    .cfg_ext1_addr(cfg_ext1_addr), .cfg_ext1_val(cfg_ext1_val),
    .cfg_en_addr(cfg_en_addr), .cfg_en_val(cfg_en_val), .cfg_data_addr(cfg_data_addr),
    .cfg_valid_desc(cfg_valid_desc), .cfg_vshift(cfg_vshift), .cfg_prescale(cfg_prescale),
    .cfg_interval(cfg_interval), .cfg_poll_gap(cfg_poll_gap), .cfg_timeout(cfg_timeout),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_ack(m_ack), .m_rdata(m_rdata), .res_data(res_data), .res_valid(res_valid),
    .tmo_pulse(tmo_pulse)
  );

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] data;
    int          gap;
    string       tag;
  } xact_t;

  xact_t       exp_q[$];
  logic [31:0] rsp_q[$];
  int          n_chk = 0, n_bad = 0;
  int          cyc = 0, last_ack = 0;
  int          tmo_seen = 0, tmo_exp = 0;
  logic [11:0] exp_data[4];
  bit          exp_flag[4];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // bus slave and monitor, acting away from the active edge
  always @(negedge clk) begin
    if (rst_n && tmo_pulse) tmo_seen++;
    if (!rst_n) m_ack = 1'b0;
    else if (m_ack) m_ack = 1'b0;
    else if (m_req) begin
      m_ack = 1'b1;
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected access", {31'd0, m_we, m_addr}, 64'd0);
      else begin
        xact_t it;
        it = exp_q.pop_front();
        chk(m_we == it.we && m_addr == it.addr, it.tag, {31'd0, m_we, m_addr}, {31'd0, it.we, it.addr});
        if (it.we) chk(m_wdata == it.data, it.tag, m_wdata, it.data);
        if (it.gap > 0) chk(cyc - last_ack >= it.gap, "R9/R10 spacing", cyc - last_ack, it.gap);
      end
      if (!m_we) m_rdata = (rsp_q.size() != 0) ? rsp_q.pop_front() : 32'd0;
      last_ack = cyc;
    end
  end

  task automatic push_x(input bit we, input logic [31:0] a, input logic [31:0] d,
                        input int gap, input string tag);
    xact_t it;
    it.we = we; it.addr = a; it.data = d; it.gap = gap; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // queue one point: nbad invalid words, then good word or a timeout
  task automatic drive_point(input int p, input int gap, input int nbad,
                             input logic [31:0] bad, input logic [31:0] good, input bit times_out);
    int g = gap;
    logic [31:0] sh;
    if (cfg_wr_ctrl[0]) begin push_x(1, cfg_pnp_addr, {24'd0, cfg_pnp_code[p*8 +: 8]}, g, "R3 pnp"); g = 0; end
    if (cfg_wr_ctrl[1]) begin push_x(1, cfg_adcmux_addr, cfg_adcmux_val, g, "R3 adcmux"); g = 0; end
    if (cfg_wr_ctrl[2]) begin push_x(1, cfg_ext_addr, cfg_ext_val, g, "R3 ext"); g = 0; end
    if (cfg_wr_ctrl[3]) begin push_x(1, cfg_ext1_addr, cfg_ext1_val, g, "R3 ext1"); g = 0; end
    push_x(1, cfg_en_addr, cfg_en_val, g, "R4 enable");
    for (int k = 0; k < nbad; k++) begin
      push_x(0, cfg_data_addr, 0, 0, "R5 poll");
      rsp_q.push_back(bad);
    end
    push_x(0, cfg_data_addr, 0, 0, "R5 poll");
    if (times_out) begin
      rsp_q.push_back(bad);
      tmo_exp++;
    end else begin
      rsp_q.push_back(good);
      sh = good >> cfg_vshift;
      exp_data[p] = sh[11:0];
      exp_flag[p] = 1'b1;
    end
  endtask

  task automatic finish_round(input string tag);
    while (exp_q.size() != 0) @(posedge clk);
    repeat (300) @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      chk(res_valid[p] == exp_flag[p], {tag, " R7 flag"}, res_valid[p], exp_flag[p]);
      chk(res_data[p*12 +: 12] == exp_data[p], {tag, " R7 data"}, res_data[p*12 +: 12], exp_data[p]);
    end
    chk(tmo_seen == tmo_exp, {tag, " R8 timeouts"}, tmo_seen, tmo_exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++) begin exp_data[p] = '0; exp_flag[p] = 1'b0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1
    chk(m_req == 1'b0, "R1 req", m_req, 0);
    chk(res_valid == 4'd0, "R1 flags", res_valid, 0);
    chk(tmo_pulse == 1'b0, "R1 tmo", tmo_pulse, 0);

    // Round A: points 0,1,3 (R2), pnp+adcmux writes, active-high flag at bit 12 (R6)
    cfg_point_en = 4'b1011; cfg_wr_ctrl = 4'b0011; cfg_valid_desc = 6'h2C; cfg_vshift = 5'd0;
    drive_point(0, SENSE*UNIT, 0, 32'h0, 32'h0000_1ABC, 0);
    drive_point(1, FILT*UNIT, 2, 32'h0000_0555, 32'h0000_1123, 0);
    drive_point(3, FILT*UNIT, 1, 32'h0000_0FFF, 32'h0000_1FFF, 0);
    finish_round("A");

    // Round B: point 2 only, extra writes only, active-low flag at bit 31, shift 4 (R6 R7)
    cfg_point_en = 4'b0100; cfg_wr_ctrl = 4'b1100; cfg_valid_desc = 6'h1F; cfg_vshift = 5'd4;
    drive_point(2, SENSE*UNIT, 1, 32'h8000_0000, 32'h0001_2340, 0);
    finish_round("B");

    // Round C: zero timeout abandons point 0, result kept (R8)
    cfg_point_en = 4'b0001; cfg_wr_ctrl = 4'b0001; cfg_valid_desc = 6'h20; cfg_timeout = 16'd0;
    drive_point(0, SENSE*UNIT, 0, 32'h0000_0000, 32'h0, 1);
    finish_round("C");

    // Round D: all points and all writes, flag at bit 5, shift 8, truncation to 12 bits
    cfg_point_en = 4'b1111; cfg_wr_ctrl = 4'b1111; cfg_valid_desc = 6'h25; cfg_vshift = 5'd8;
    cfg_timeout = 16'hFFFF;
    drive_point(0, SENSE*UNIT, 0, 32'h0, 32'hFFFF_FF20, 0);
    drive_point(1, FILT*UNIT, 1, 32'h0000_0001, 32'h0003_4520, 0);
    drive_point(2, FILT*UNIT, 0, 32'h0, 32'h0000_0720, 0);
    drive_point(3, FILT*UNIT, 2, 32'h0000_0010, 32'h0000_AB20, 0);
    finish_round("D");

    // Round E: empty mask, no bus traffic at all (R2)
    cfg_point_en = 4'b0000;
    repeat (1500) @(posedge clk);
    finish_round("E");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule